// File: doc/BRIEF.md
# Sector Bit-Flip Corrector for BCH Error Locations

This block takes a list of error bit positions, already found by an external BCH locator, and repairs a 512-byte sector kept in its own dual-port byte RAM. The host first fills the sector through a byte port. It then presents the code strength, the number of errors, the packed location words and the ECC bytes that were read from the spare area, and pulses `start`. The block walks the list in order and toggles each addressed data bit with a read-then-write sequence. It finally pulses `done` and reports how many bits it changed. The host then reads the repaired sector back through the same byte port.

Locations are numbered in codeword order, with the parity bits first. A location inside the parity region is dropped. A data location is converted to a byte index counted from the end of the sector, and a bit index taken from its low three bits. When every checked stored ECC byte is 0xFF, the sector is taken as an erased page and no bit is touched.

Top module: `ecc_bitfix`

## Requirements
- R1: After reset, `busy`, `done` and `flip_count` are 0.
- R2: A byte written with `host_we` at `host_addr` appears on `host_rdata` one clock after that address is presented.
- R3: `level` sets the parity length P in bits: code 0 gives 52, code 1 gives 104, code 2 gives 208, and code 3 behaves as code 1. Any location below P is skipped without a flip.
- R4: For a location L with d = L - P and d < 4096, byte 511 - (d div 8) of the sector has bit (d mod 8) inverted. A location with d >= 4096 is skipped.
- R5: The stored ECC bytes arrive on `ecc_stored`, with byte i at bits [8i+7:8i]. The first N of them are checked, where N is 8 for code 0, 26 for code 2 and 14 otherwise. If all N equal 0xFF, no bit is changed and `flip_count` ends at 0. Bytes beyond N do not affect this test.
- R6: Entry i of the list lies at `err_locs[13i+12:13i]`. An `err_count` above 8 is treated as 8.
- R7: `busy` rises in the cycle after an accepted `start`. `done` is a single-cycle pulse while `busy` is still high, and `busy` falls in the next cycle.
- R8: `flip_count` equals the number of bits actually inverted in the run. It is cleared by an accepted `start` and held until the next one.
- R9: A `start` that arrives while `busy` is high is ignored: it produces no extra `done` and no change to the sector.
- R10: Entries are applied in list order, one after another. Two entries naming the same bit cancel each other and both count. Two entries naming different bits of one byte both take effect.
- R11: An `err_count` of 0 still produces `done`, with no change to the sector and `flip_count` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host byte write enable |
| host_addr | input | 9 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, one cycle latency |
| level | input | 2 | Code strength select |
| err_count | input | 4 | Number of valid location entries |
| err_locs | input | 104 | Packed codeword bit locations, 13 bits each |
| ecc_stored | input | 208 | Stored ECC bytes for the erased-page test |
| start | input | 1 | Begin a correction run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| flip_count | output | 4 | Bits inverted in the last run |

## Verification
The case where two functions meet in one place is a write-back that is followed at once by the read for the next entry at the same byte. The write for one entry and the read for the next fall on consecutive edges of the same RAM word, so a stale read would lose the first fix. This is provoked with lists that name the same bit twice, which must cancel, and two bits of one byte, which must both stick. The result is judged by reading back the whole sector against a byte model. A second `start` issued in the middle of a run is also judged by the absence of any extra `done` and by an unchanged sector.

// File: rtl/ecc_bitfix_pkg.sv
package ecc_bitfix_pkg;

   typedef enum logic [1:0] {
      LVL_T4  = 2'd0,
      LVL_T8  = 2'd1,
      LVL_T16 = 2'd2,
      LVL_RSV = 2'd3
   } lvl_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EVAL  = 2'd1,
      ST_WRITE = 2'd2,
      ST_FIN   = 2'd3
   } fix_st_e;

   // parity region length in bits for each strength
   function automatic int unsigned parity_bits(input logic [1:0] lv);
      case (lv)
         LVL_T4:  parity_bits = 52;
         LVL_T16: parity_bits = 208;
         default: parity_bits = 104;
      endcase
   endfunction

   // stored ECC bytes examined by the erased-page test
   function automatic int unsigned check_bytes(input logic [1:0] lv);
      case (lv)
         LVL_T4:  check_bytes = 8;
         LVL_T16: check_bytes = 26;
         default: check_bytes = 14;
      endcase
   endfunction

endpackage

// File: rtl/ecc_bitfix_ram.sv
module ecc_bitfix_ram #(
   parameter int DEPTH  = 512,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [7:0]        a_wdata,
   output logic [7:0]        a_rdata,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [7:0]        b_wdata,
   output logic [7:0]        b_rdata
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (a_we) mem[a_addr] <= a_wdata;
      if (b_we) mem[b_addr] <= b_wdata;
      a_rdata <= mem[a_addr];
      b_rdata <= mem[b_addr];
   end
endmodule

// File: rtl/ecc_bitfix_xlate.sv
module ecc_bitfix_xlate
   import ecc_bitfix_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int LOC_W        = 13,
   parameter int ADDR_W       = $clog2(SECTOR_BYTES)
) (
   input  logic [1:0]        lv,
   input  logic [LOC_W-1:0]  loc,
   output logic              hit,
   output logic [ADDR_W-1:0] byte_addr,
   output logic [2:0]        bit_sel
);
   localparam int DATA_BITS = SECTOR_BYTES * 8;
   localparam int XW        = LOC_W + 1;

   logic [XW-1:0] pb;
   logic [XW-1:0] d;
   logic          in_par;
   logic          past_end;

   always_comb begin
      pb        = XW'(parity_bits(lv));
      d         = {1'b0, loc} - pb;
      in_par    = ({1'b0, loc} < pb);
      past_end  = (d >= XW'(DATA_BITS));
      hit       = !in_par && !past_end;
      byte_addr = ADDR_W'(SECTOR_BYTES - 1) - ADDR_W'(d >> 3);
      bit_sel   = d[2:0];
   end
endmodule

// File: rtl/ecc_bitfix_erase.sv
module ecc_bitfix_erase
   import ecc_bitfix_pkg::*;
#(
   parameter int ECC_MAX = 26
) (
   input  logic [1:0]           lv,
   input  logic [ECC_MAX*8-1:0] ecc,
   output logic                 erased
);
   logic [ECC_MAX-1:0] ok;
   int unsigned        nchk;

   assign nchk = check_bytes(lv);

   for (genvar i = 0; i < ECC_MAX; i++) begin : g_byte
      assign ok[i] = (ecc[i*8 +: 8] == 8'hFF) || (i >= nchk);
   end

   assign erased = &ok;
endmodule

// File: rtl/ecc_bitfix_ctrl.sv
module ecc_bitfix_ctrl
   import ecc_bitfix_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int MAX_ERR      = 8,
   parameter int LOC_W        = 13,
   parameter int ADDR_W       = $clog2(SECTOR_BYTES),
   parameter int CNT_W        = $clog2(MAX_ERR + 1),
   parameter int IDX_W        = $clog2(MAX_ERR)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [1:0]               lv_in,
   input  logic [CNT_W-1:0]         cnt_in,
   input  logic [MAX_ERR*LOC_W-1:0] loc_in,
   input  logic                     erased,
   output logic                     ram_we,
   output logic [ADDR_W-1:0]        ram_addr,
   output logic [7:0]               ram_wdata,
   input  logic [7:0]               ram_rdata,
   output logic                     busy,
   output logic                     done,
   output logic [CNT_W-1:0]         flips
);
   fix_st_e           st;
   logic [LOC_W-1:0]  loc_q [MAX_ERR];
   logic [1:0]        lv_q;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  last;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        mask_q;
   logic [CNT_W-1:0]  eff;

   logic              xl_hit;
   logic [ADDR_W-1:0] xl_addr;
   logic [2:0]        xl_bit;

   ecc_bitfix_xlate #(
      .SECTOR_BYTES(SECTOR_BYTES),
      .LOC_W       (LOC_W),
      .ADDR_W      (ADDR_W)
   ) u_xlate (
      .lv       (lv_q),
      .loc      (loc_q[idx]),
      .hit      (xl_hit),
      .byte_addr(xl_addr),
      .bit_sel  (xl_bit)
   );

   assign eff = (cnt_in > CNT_W'(MAX_ERR)) ? CNT_W'(MAX_ERR) : cnt_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         lv_q   <= '0;
         idx    <= '0;
         last   <= '0;
         addr_q <= '0;
         mask_q <= '0;
         flips  <= '0;
         for (int i = 0; i < MAX_ERR; i++) loc_q[i] <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start) begin
                  lv_q  <= lv_in;
                  flips <= '0;
                  idx   <= '0;
                  last  <= IDX_W'(eff - 1'b1);
                  for (int i = 0; i < MAX_ERR; i++)
                     loc_q[i] <= loc_in[i*LOC_W +: LOC_W];
                  st <= (erased || eff == '0) ? ST_FIN : ST_EVAL;
               end
            end
            ST_EVAL: begin
               if (xl_hit) begin
                  addr_q <= xl_addr;
                  mask_q <= 8'b1 << xl_bit;
                  st     <= ST_WRITE;
               end else if (idx == last) begin
                  st <= ST_FIN;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_WRITE: begin
               flips <= flips + 1'b1;
               if (idx == last) begin
                  st <= ST_FIN;
               end else begin
                  idx <= idx + 1'b1;
                  st  <= ST_EVAL;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign ram_we    = (st == ST_WRITE);
   assign ram_addr  = (st == ST_WRITE) ? addr_q : xl_addr;
   assign ram_wdata = ram_rdata ^ mask_q;
   assign busy      = (st != ST_IDLE);
   assign done      = (st == ST_FIN);
endmodule

// File: rtl/ecc_bitfix.sv
module ecc_bitfix
   import ecc_bitfix_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int MAX_ERR      = 8,
   parameter int LOC_W        = 13,
   parameter int ECC_MAX      = 26,
   parameter bit ERASE_CHECK  = 1'b1,
   localparam int ADDR_W      = $clog2(SECTOR_BYTES),
   localparam int CNT_W       = $clog2(MAX_ERR + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     host_we,
   input  logic [ADDR_W-1:0]        host_addr,
   input  logic [7:0]               host_wdata,
   output logic [7:0]               host_rdata,
   input  logic [1:0]               level,
   input  logic [CNT_W-1:0]         err_count,
   input  logic [MAX_ERR*LOC_W-1:0] err_locs,
   input  logic [ECC_MAX*8-1:0]     ecc_stored,
   input  logic                     start,
   output logic                     busy,
   output logic                     done,
   output logic [CNT_W-1:0]         flip_count
);
   localparam int IDX_W = $clog2(MAX_ERR);

   // elaboration-time parameter checks
   if (MAX_ERR < 2) begin : g_bad_max
      $error("MAX_ERR must be at least 2");
   end
   if ((2 ** LOC_W) < SECTOR_BYTES * 8 + 208) begin : g_bad_loc
      $error("LOC_W too narrow for sector plus widest parity");
   end
   if (ECC_MAX < 26) begin : g_bad_ecc
      $error("ECC_MAX must cover the widest erased-page test");
   end
   if ((2 ** ADDR_W) != SECTOR_BYTES) begin : g_bad_sec
      $error("SECTOR_BYTES must be a power of two");
   end

   logic              erased;
   logic              e_we;
   logic [ADDR_W-1:0] e_addr;
   logic [7:0]        e_wdata;
   logic [7:0]        e_rdata;

   if (ERASE_CHECK) begin : g_erase
      ecc_bitfix_erase #(.ECC_MAX(ECC_MAX)) u_erase (
         .lv    (level),
         .ecc   (ecc_stored),
         .erased(erased)
      );
   end else begin : g_no_erase
      assign erased = 1'b0;
   end

   ecc_bitfix_ram #(
      .DEPTH (SECTOR_BYTES),
      .ADDR_W(ADDR_W)
   ) u_ram (
      .clk    (clk),
      .a_we   (host_we),
      .a_addr (host_addr),
      .a_wdata(host_wdata),
      .a_rdata(host_rdata),
      .b_we   (e_we),
      .b_addr (e_addr),
      .b_wdata(e_wdata),
      .b_rdata(e_rdata)
   );

   ecc_bitfix_ctrl #(
      .SECTOR_BYTES(SECTOR_BYTES),
      .MAX_ERR     (MAX_ERR),
      .LOC_W       (LOC_W),
      .ADDR_W      (ADDR_W),
      .CNT_W       (CNT_W),
      .IDX_W       (IDX_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .lv_in    (level),
      .cnt_in   (err_count),
      .loc_in   (err_locs),
      .erased   (erased),
      .ram_we   (e_we),
      .ram_addr (e_addr),
      .ram_wdata(e_wdata),
      .ram_rdata(e_rdata),
      .busy     (busy),
      .done     (done),
      .flips    (flip_count)
   );
endmodule

module ecc_bitfix_chk #(
   parameter int MAX_ERR = 8,
   parameter int CNT_W   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [CNT_W-1:0] flip_count
);
   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7
   done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   // R7
   start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);
   // R7
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   // R8
   flip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(flip_count));
   // R8
   flip_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flip_count <= CNT_W'(MAX_ERR));
endmodule

bind ecc_bitfix ecc_bitfix_chk #(.MAX_ERR(MAX_ERR), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .flip_count(flip_count)
);

// File: tb/ecc_bitfix_bench.sv
`timescale 1ns/1ps
module ecc_bitfix_bench;
   localparam int NB = 512;
   localparam int NE = 8;
   localparam int LW = 13;
   localparam int NECC = 26;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             host_we = 1'b0;
   logic [8:0]       host_addr = '0;
   logic [7:0]       host_wdata = '0;
   logic [7:0]       host_rdata;
   logic [1:0]       level = '0;
   logic [3:0]       err_count = '0;
   logic [NE*LW-1:0] err_locs = '0;
   logic [NECC*8-1:0] ecc_stored = '0;
   logic             start = 1'b0;
   logic             busy, done;
   logic [3:0]       flip_count;

   always #2.5 clk = ~clk;

   ecc_bitfix u_ecc_bitfix (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .level(level), .err_count(err_count),
      .err_locs(err_locs), .ecc_stored(ecc_stored), .start(start),
      .busy(busy), .done(done), .flip_count(flip_count)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0]  model [NB];
   logic [12:0] locs  [NE];
   int          sb_q [$];
   int          last_flips = 0;
   logic        done_d = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on each done pulse
   always @(negedge clk) begin
      if (rst_n) begin
         if (done_d && done) check(1'b0, "R7 done wider than one cycle", 1, 0);
         if (done) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R9 unexpected done", 1, 0);
            end else begin
               int e;
               e = sb_q.pop_front();
               check(flip_count == 4'(e), "R8 flip_count at done", int'(flip_count), e);
            end
         end
         done_d <= done;
      end
   end

   task automatic verify_sector(input string req);
      int bad = 0;
      int first_act = 0;
      int first_exp = 0;
      for (int a = 0; a < NB; a++) begin
         @(negedge clk);
         host_addr = 9'(a);
         @(negedge clk);
         if (host_rdata !== model[a]) begin
            if (bad == 0) begin
               first_act = int'(host_rdata);
               first_exp = int'(model[a]);
            end
            bad++;
         end
      end
      check(bad == 0, req, first_act, first_exp);
   endtask

   function automatic int par_len(input logic [1:0] lv);
      return (lv == 2'd0) ? 52 : (lv == 2'd2) ? 208 : 104;
   endfunction

   function automatic int chk_len(input logic [1:0] lv);
      return (lv == 2'd0) ? 8 : (lv == 2'd2) ? 26 : 14;
   endfunction

   // driver: computes the expectation, pushes it, and launches the run
   task automatic run_case(input string req, input logic [1:0] lv, input int n,
                           input logic [NECC*8-1:0] ecc, input bit poke);
      int  flips = 0;
      int  m;
      bit  er = 1'b1;
      for (int i = 0; i < chk_len(lv); i++)
         if (ecc[i*8 +: 8] != 8'hFF) er = 1'b0;
      m = (n > NE) ? NE : n;
      if (!er) begin
         for (int i = 0; i < m; i++) begin
            int d;
            d = int'(locs[i]) - par_len(lv);
            if (d >= 0 && d < NB * 8) begin
               model[NB - 1 - d / 8] ^= 8'(1 << (d % 8));
               flips++;
            end
         end
      end
      sb_q.push_back(flips);
      last_flips = flips;
      @(negedge clk);
      level = lv;
      err_count = 4'(n);
      for (int i = 0; i < NE; i++) err_locs[i*LW +: LW] = locs[i];
      ecc_stored = ecc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, {req, " / R7 busy after start"}, int'(busy), 1);
      if (poke) begin
         @(negedge clk);
         for (int i = 0; i < NE; i++) err_locs[i*LW +: LW] = 13'd300;
         err_count = 4'd8;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      @(negedge clk);
      check(busy == 1'b0, {req, " / R7 busy after done"}, int'(busy), 0);
      verify_sector({req, " sector"});
   endtask

   task automatic clear_locs();
      for (int i = 0; i < NE; i++) locs[i] = 13'd0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [NECC*8-1:0] ecc0;
      logic [NECC*8-1:0] eccx;
      ecc0 = '0;
      repeat (4) @(negedge clk);
      check(busy == 0 && done == 0 && flip_count == 0, "R1 reset state",
            int'(flip_count) + int'(busy) + int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 load the sector
      for (int a = 0; a < NB; a++) begin
         host_we = 1'b1;
         host_addr = 9'(a);
         host_wdata = 8'((a * 37 + 5) & 255);
         model[a] = 8'((a * 37 + 5) & 255);
         @(negedge clk);
      end
      host_we = 1'b0;
      verify_sector("R2 host load readback");

      // R4 first data bit
      clear_locs(); locs[0] = 13'd104;
      run_case("R4 first data bit", 2'd1, 1, ecc0, 1'b0);
      check(flip_count == 4'd1, "R8 flip_count held", int'(flip_count), 1);

      // R3 parity locations skipped
      clear_locs(); locs[0] = 13'd103; locs[1] = 13'd0;
      run_case("R3 parity skip level1", 2'd1, 2, ecc0, 1'b0);

      // R3 level 0 boundary
      clear_locs(); locs[0] = 13'd51; locs[1] = 13'd52; locs[2] = 13'd60;
      run_case("R3 level0 boundary", 2'd0, 3, ecc0, 1'b0);

      // R3 level 2 boundary and last data bit
      clear_locs(); locs[0] = 13'd207; locs[1] = 13'd208; locs[2] = 13'd4303;
      run_case("R3 level2 boundary", 2'd2, 3, ecc0, 1'b0);

      // R4 past the data region
      clear_locs(); locs[0] = 13'd4200; locs[1] = 13'd4199;
      run_case("R4 past data end", 2'd1, 2, ecc0, 1'b0);

      // R3 code 3 behaves as code 1
      clear_locs(); locs[0] = 13'd103; locs[1] = 13'd150;
      run_case("R3 level3 as level1", 2'd3, 2, ecc0, 1'b0);

      // R5 erased page
      clear_locs(); locs[0] = 13'd500;
      run_case("R5 erased all FF", 2'd1, 1, {NECC{8'hFF}}, 1'b0);
      eccx = '0;
      for (int i = 0; i < 14; i++) eccx[i*8 +: 8] = 8'hFF;
      run_case("R5 erased tail ignored", 2'd1, 1, eccx, 1'b0);
      eccx[13*8 +: 8] = 8'hFE;
      run_case("R5 last checked byte not FF", 2'd1, 1, eccx, 1'b0);
      eccx = '0;
      for (int i = 0; i < 8; i++) eccx[i*8 +: 8] = 8'hFF;
      run_case("R5 level0 eight bytes", 2'd0, 1, eccx, 1'b0);

      // R6 count clamp
      for (int i = 0; i < NE; i++) locs[i] = 13'(1000 + 9 * i);
      run_case("R6 count clamp", 2'd1, 10, ecc0, 1'b0);

      // R10 same bit twice, two bits of one byte
      clear_locs(); locs[0] = 13'd2000; locs[1] = 13'd2000;
      locs[2] = 13'd2008; locs[3] = 13'd2011;
      run_case("R10 ordered same byte", 2'd1, 4, ecc0, 1'b0);

      // R11 empty list
      clear_locs(); locs[0] = 13'd700;
      run_case("R11 zero count", 2'd1, 0, ecc0, 1'b0);
      check(flip_count == 4'd0, "R11 flip_count zero", int'(flip_count), 0);

      // R9 start while busy
      for (int i = 0; i < NE; i++) locs[i] = 13'(3000 + 17 * i);
      run_case("R9 start while busy", 2'd1, 8, ecc0, 1'b1);
      repeat (30) @(negedge clk);
      check(sb_q.size() == 0, "R9 no extra done", sb_q.size(), 0);
      check(flip_count == 4'(last_flips), "R8 flip_count held idle",
            int'(flip_count), last_flips);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule